// File: doc/BRIEF.md
# Threaded Instruction Line Requester

This block sits in the fetch stage of a multithreaded core and gets whole instruction cache lines for up to four threads. Each cycle one thread may present a fetch address. The block clears the offset bits of the address to get the line address and compares it with that thread's private line buffer. On a match the thread goes ahead in the same cycle and no memory traffic is created. On a miss the block sends one line-sized read to the instruction cache.

The cache may turn a request away. A refused request is parked in a single retry slot that all threads share. While that slot is in use, every thread is barred from starting a new line read. A retry pulse from the cache replays the parked request. Responses come back tagged with a thread number and a small per-thread sequence number. A response is written into the line buffer only if its thread is still waiting and the sequence number is the current one. Any other response is thrown away and counted. A squash for a thread cancels that thread's outstanding miss and frees the retry slot if the thread owns it.

Top module: `ifl_requester`

## Requirements
- R1: The line address is the fetch address with its low log2(BLOCK_BYTES) bits forced to zero. It is used both for the buffer comparison and as `reqAddr` of a new read.
- R2: A thread is eligible to fetch when it is in run state, is not stalled and is not being squashed. If an eligible thread presents an address and its buffer is valid with a tag equal to the line address, `fetchHit` is high in that cycle, `reqValid` stays low, and `lineData` shows the buffered line.
- R3: If a new read is refused (`reqReady` low), then from the next cycle `fetchBlocked` is high, the thread reads wait-retry (2), and no thread starts a new read until the blocked flag clears.
- R4: A retry pulse while a request is parked drives that request again in the same cycle, with the same address, thread and sequence number. If it is accepted, the thread moves to wait-response (1), the slot empties and `fetchBlocked` falls. A retry pulse with an empty slot only clears `fetchBlocked`.
- R5: A response is accepted only if its thread is in wait-response, its `rspSeq` equals that thread's current sequence number, and the thread is not squashed in that cycle. Every other response increments `dropCount` (wrapping) and leaves all thread state unchanged.
- R6: An accepted response writes `rspData` into the thread's buffer and sets its `lineValid` bit. The thread goes to access-complete (3), or to blocked (4) if its stall input is high. Access-complete returns to run on the next cycle, or goes to blocked if stalled.
- R7: A squash puts the thread in run state (0) on the next cycle and cancels its outstanding miss. If the thread owns the retry slot, the slot empties, but `fetchBlocked` stays high until the next retry pulse.
- R8: Starting a new read clears the thread's `lineValid` bit, stores the line address as its tag, and increments its sequence number modulo 2^SEQ_W. The new value is carried on `reqSeq`.
- R9: A thread in run state with its stall input high moves to blocked (4). A blocked thread with stall low returns to run. A stalled thread neither hits nor starts a read. Stall has no effect on the two wait states.
- R10: After reset, every thread is in run state, all `lineValid` bits are 0, `fetchBlocked` is 0 and `dropCount` is 0. Thread t's state is at `threadState[3t+2:3t]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A thread presents a fetch address this cycle |
| fetchTid | input | 2 | Thread presenting the address |
| fetchPc | input | ADDR_W | Fetch address |
| stall | input | NUM_THREADS | Per-thread stall from later stages |
| squash | input | NUM_THREADS | Per-thread squash |
| reqValid | output | 1 | Line read request to the cache |
| reqAddr | output | ADDR_W | Line-aligned request address |
| reqTid | output | 2 | Requesting thread |
| reqSeq | output | SEQ_W | Sequence number of the request |
| reqReady | input | 1 | Cache accepts the request this cycle |
| retryPulse | input | 1 | Cache can now take a refused request |
| rspValid | input | 1 | Response present |
| rspTid | input | 2 | Thread tag of the response |
| rspSeq | input | SEQ_W | Sequence tag of the response |
| rspData | input | BLOCK_BYTES*8 | Line data |
| fetchHit | output | 1 | Presented address hits the thread's buffer |
| lineData | output | BLOCK_BYTES*8 | Buffered line of the presenting thread |
| lineValid | output | NUM_THREADS | Per-thread buffer valid |
| threadState | output | 3*NUM_THREADS | Per-thread state code |
| fetchBlocked | output | 1 | Shared retry block flag |
| dropCount | output | CNT_W | Discarded responses |

## Verification
A corrupted per-thread state shows up within one cycle. Wrong state codes make `threadState` diverge at once. They also either suppress `reqValid` where a read is due or cause a read where none is allowed. A stale sequence number or tag is harder to spot: it only appears when the next response or hit for that thread arrives, as an unexpected change in `dropCount` or `fetchHit`. For that reason the random phase keeps addresses in a small set and aims most responses at the current sequence number. A retry slot that was not cleared after a squash shows up at the next retry pulse as a request that should not be there.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  localparam int TID_W = 2;

  typedef enum logic [2:0] {
    TS_RUN      = 3'd0,
    TS_WAIT_RSP = 3'd1,
    TS_WAIT_RTY = 3'd2,
    TS_DONE     = 3'd3,
    TS_BLOCKED  = 3'd4
  } thr_state_e;

  typedef struct packed {
    logic             issueEn;
    logic [TID_W-1:0] issueTid;
    logic             fillEn;
    logic [TID_W-1:0] fillTid;
    logic             dropEn;
  } ifl_strobe_t;
endpackage

// File: rtl/ifl_datapath.sv
module ifl_datapath
  import ifl_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int CNT_W       = 8,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int DATA_W     = BLOCK_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TID_W-1:0]       fetchTid,
  input  logic [ADDR_W-1:0]      fetchPc,
  input  ifl_strobe_t            stb,
  input  logic [DATA_W-1:0]      rspData,
  output logic [ADDR_W-1:0]      alignedPc,
  output logic                   rawHit,
  output logic [DATA_W-1:0]      lineData,
  output logic [NUM_THREADS-1:0] lineValid,
  output logic [CNT_W-1:0]       dropCount
);
  logic [ADDR_W-1:0] lineTag  [NUM_THREADS];
  logic [DATA_W-1:0] lineBuf  [NUM_THREADS];
  logic [OFF_W-1:0]  unusedPcOffset;

  assign unusedPcOffset = fetchPc[OFF_W-1:0];
  assign alignedPc = {fetchPc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign rawHit    = lineValid[fetchTid] && (lineTag[fetchTid] == alignedPc);
  assign lineData  = lineBuf[fetchTid];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
      dropCount <= '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
        lineTag[t] <= '0;
        lineBuf[t] <= '0;
      end
    end else begin
      if (stb.issueEn) begin
        lineValid[stb.issueTid] <= 1'b0;
        lineTag[stb.issueTid]   <= alignedPc;
      end
      if (stb.fillEn) begin
        lineValid[stb.fillTid] <= 1'b1;
        lineBuf[stb.fillTid]   <= rspData;
      end
      if (stb.dropEn) dropCount <= dropCount + CNT_W'(1);
    end
  end

  p_fill_sets_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.fillEn |=> lineValid[$past(stb.fillTid)]);
  p_issue_clears_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueEn |=> !lineValid[$past(stb.issueTid)]);
  p_drop_counts_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropEn |=> dropCount != $past(dropCount));
endmodule

// File: rtl/ifl_ctrl.sv
module ifl_ctrl
  import ifl_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  parameter int SEQ_W       = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fetchValid,
  input  logic [TID_W-1:0]         fetchTid,
  input  logic [ADDR_W-1:0]        alignedPc,
  input  logic                     rawHit,
  input  logic [NUM_THREADS-1:0]   stall,
  input  logic [NUM_THREADS-1:0]   squash,
  input  logic                     reqReady,
  input  logic                     retryPulse,
  input  logic                     rspValid,
  input  logic [TID_W-1:0]         rspTid,
  input  logic [SEQ_W-1:0]         rspSeq,
  output logic                     reqValid,
  output logic [ADDR_W-1:0]        reqAddr,
  output logic [TID_W-1:0]         reqTid,
  output logic [SEQ_W-1:0]         reqSeq,
  output logic                     fetchHit,
  output logic                     fetchBlocked,
  output logic [3*NUM_THREADS-1:0] threadState,
  output ifl_strobe_t              stb
);
  thr_state_e        st  [NUM_THREADS];
  logic [SEQ_W-1:0]  seq [NUM_THREADS];
  logic              slotV;
  logic [TID_W-1:0]  slotTid;
  logic [ADDR_W-1:0] slotAddr;
  logic              runOk, issue, resend, accept;

  always_comb begin
    runOk  = (st[fetchTid] == TS_RUN) && !squash[fetchTid] && !stall[fetchTid];
    issue  = fetchValid && runOk && !rawHit && !fetchBlocked;
    resend = retryPulse && slotV && !squash[slotTid];
    accept = rspValid && (st[rspTid] == TS_WAIT_RSP) &&
             (rspSeq == seq[rspTid]) && !squash[rspTid];
  end

  assign reqValid = issue || resend;
  assign reqAddr  = resend ? slotAddr : alignedPc;
  assign reqTid   = resend ? slotTid  : fetchTid;
  assign reqSeq   = resend ? seq[slotTid] : seq[fetchTid] + SEQ_W'(1);
  assign fetchHit = fetchValid && runOk && rawHit;

  always_comb begin
    stb          = '0;
    stb.issueEn  = issue;
    stb.issueTid = fetchTid;
    stb.fillEn   = accept;
    stb.fillTid  = rspTid;
    stb.dropEn   = rspValid && !accept;
  end

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_state_out
    assign threadState[3*g +: 3] = st[g];
    p_squash_to_run_r7: assert property (@(posedge clk) disable iff (!rstN)
      squash[g] |=> st[g] == TS_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchBlocked <= 1'b0;
      slotV        <= 1'b0;
      slotTid      <= '0;
      slotAddr     <= '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
        st[t]  <= TS_RUN;
        seq[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (squash[t]) st[t] <= TS_RUN;
        else if (issue && fetchTid == TID_W'(t))
          st[t] <= reqReady ? TS_WAIT_RSP : TS_WAIT_RTY;
        else if (resend && reqReady && slotTid == TID_W'(t))
          st[t] <= TS_WAIT_RSP;
        else if (accept && rspTid == TID_W'(t))
          st[t] <= stall[t] ? TS_BLOCKED : TS_DONE;
        else begin
          case (st[t])
            TS_RUN:     if (stall[t]) st[t] <= TS_BLOCKED;
            TS_DONE:    st[t] <= stall[t] ? TS_BLOCKED : TS_RUN;
            TS_BLOCKED: if (!stall[t]) st[t] <= TS_RUN;
            default: ;
          endcase
        end
        if (issue && fetchTid == TID_W'(t)) seq[t] <= seq[t] + SEQ_W'(1);
      end

      if (issue && !reqReady) fetchBlocked <= 1'b1;
      else if (retryPulse) fetchBlocked <= resend && !reqReady;

      if (issue && !reqReady) begin
        slotV    <= 1'b1;
        slotTid  <= fetchTid;
        slotAddr <= alignedPc;
      end else if (resend && reqReady) slotV <= 1'b0;
      else if (slotV && squash[slotTid]) slotV <= 1'b0;
    end
  end

  p_slot_needs_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    slotV |-> fetchBlocked);
  p_issue_not_blocked_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueEn |-> !fetchBlocked);
  p_empty_retry_unblocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (retryPulse && !slotV && !(issue && !reqReady)) |=> !fetchBlocked);
  p_fill_needs_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.fillEn |-> st[rspTid] == TS_WAIT_RSP);
endmodule

// File: rtl/ifl_requester.sv
module ifl_requester
  import ifl_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int SEQ_W       = 2,
  parameter int CNT_W       = 8,
  localparam int DATA_W     = BLOCK_BYTES * 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fetchValid,
  input  logic [TID_W-1:0]         fetchTid,
  input  logic [ADDR_W-1:0]        fetchPc,
  input  logic [NUM_THREADS-1:0]   stall,
  input  logic [NUM_THREADS-1:0]   squash,
  output logic                     reqValid,
  output logic [ADDR_W-1:0]        reqAddr,
  output logic [TID_W-1:0]         reqTid,
  output logic [SEQ_W-1:0]         reqSeq,
  input  logic                     reqReady,
  input  logic                     retryPulse,
  input  logic                     rspValid,
  input  logic [TID_W-1:0]         rspTid,
  input  logic [SEQ_W-1:0]         rspSeq,
  input  logic [DATA_W-1:0]        rspData,
  output logic                     fetchHit,
  output logic [DATA_W-1:0]        lineData,
  output logic [NUM_THREADS-1:0]   lineValid,
  output logic [3*NUM_THREADS-1:0] threadState,
  output logic                     fetchBlocked,
  output logic [CNT_W-1:0]         dropCount
);
  ifl_strobe_t       stb;
  logic [ADDR_W-1:0] alignedPc;
  logic              rawHit;

  ifl_ctrl #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchTid(fetchTid),
    .alignedPc(alignedPc), .rawHit(rawHit), .stall(stall), .squash(squash),
    .reqReady(reqReady), .retryPulse(retryPulse), .rspValid(rspValid),
    .rspTid(rspTid), .rspSeq(rspSeq), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqTid(reqTid), .reqSeq(reqSeq), .fetchHit(fetchHit),
    .fetchBlocked(fetchBlocked), .threadState(threadState), .stb(stb));

  ifl_datapath #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W),
                 .BLOCK_BYTES(BLOCK_BYTES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .fetchTid(fetchTid), .fetchPc(fetchPc), .stb(stb),
    .rspData(rspData), .alignedPc(alignedPc), .rawHit(rawHit),
    .lineData(lineData), .lineValid(lineValid), .dropCount(dropCount));
endmodule

// File: tb/ifl_requester_bench.sv
`timescale 1ns/1ps
module ifl_requester_bench;
  localparam int NT = 4, AW = 32, BB = 32, SW = 2, CW = 8, DW = BB * 8;

  logic clk = 0, rstN = 0;
  logic fetchValid = 0, reqReady = 1, retryPulse = 0, rspValid = 0;
  logic [1:0] fetchTid = 0, rspTid = 0, reqTid;
  logic [AW-1:0] fetchPc = 0, reqAddr;
  logic [NT-1:0] stall = 0, squash = 0, lineValid;
  logic [SW-1:0] rspSeq = 0, reqSeq;
  logic [DW-1:0] rspData = 0, lineData;
  logic reqValid, fetchHit, fetchBlocked;
  logic [3*NT-1:0] threadState;
  logic [CW-1:0] dropCount;

  always #5 clk = ~clk;

  ifl_requester u_ifl_requester (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchTid(fetchTid),
    .fetchPc(fetchPc), .stall(stall), .squash(squash), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqTid(reqTid), .reqSeq(reqSeq), .reqReady(reqReady),
    .retryPulse(retryPulse), .rspValid(rspValid), .rspTid(rspTid),
    .rspSeq(rspSeq), .rspData(rspData), .fetchHit(fetchHit),
    .lineData(lineData), .lineValid(lineValid), .threadState(threadState),
    .fetchBlocked(fetchBlocked), .dropCount(dropCount));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mState[NT], mSeq[NT], mDrop;
  bit mValid[NT], mBlocked, mSlotV;
  longint mTag[NT], mSlotAddr;
  int mSlotTid;
  logic [DW-1:0] mData[NT];

  always @(negedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NT; t++) begin
        mState[t] = 0; mSeq[t] = 0; mValid[t] = 0; mTag[t] = 0; mData[t] = 0;
      end
      mDrop = 0; mBlocked = 0; mSlotV = 0; mSlotTid = 0; mSlotAddr = 0;
    end else if (!done) begin
      automatic int ft = fetchTid, rt = rspTid;
      automatic longint al = fetchPc & ~longint'(BB - 1);
      automatic bit hit = mValid[ft] && mTag[ft] == al;
      automatic bit run = mState[ft] == 0 && !squash[ft] && !stall[ft];
      automatic bit resend = retryPulse && mSlotV && !squash[mSlotTid];
      automatic bit issue = fetchValid && run && !hit && !mBlocked;
      automatic bit acc = rspValid && mState[rt] == 1 && rspSeq == mSeq[rt] && !squash[rt];
      // compare
      chk(reqValid == (issue || resend), "R3", "reqValid", reqValid, issue || resend);
      if (issue) begin
        chk(reqAddr == al, "R1", "reqAddr", reqAddr, al);
        chk(reqSeq == SW'(mSeq[ft] + 1), "R8", "reqSeq", reqSeq, SW'(mSeq[ft] + 1));
      end
      if (resend) begin
        chk(reqAddr == mSlotAddr && reqTid == mSlotTid, "R4", "resend addr", reqAddr, mSlotAddr);
        chk(reqSeq == SW'(mSeq[mSlotTid]), "R4", "resend seq", reqSeq, mSeq[mSlotTid]);
      end
      chk(fetchHit == (fetchValid && run && hit), "R2", "fetchHit", fetchHit, fetchValid && run && hit);
      if (fetchValid && mValid[ft])
        chk(lineData == mData[ft], "R6", "lineData", lineData[31:0], mData[ft][31:0]);
      chk(fetchBlocked == mBlocked, "R3", "fetchBlocked", fetchBlocked, mBlocked);
      chk(dropCount == CW'(mDrop), "R5", "dropCount", dropCount, CW'(mDrop));
      for (int t = 0; t < NT; t++) begin
        chk(threadState[3*t +: 3] == mState[t], "R9", "threadState", threadState[3*t +: 3], mState[t]);
        chk(lineValid[t] == mValid[t], "R8", "lineValid", lineValid[t], mValid[t]);
      end
      // advance
      for (int t = 0; t < NT; t++) begin
        if (squash[t]) mState[t] = 0;
        else if (issue && ft == t) mState[t] = reqReady ? 1 : 2;
        else if (resend && reqReady && mSlotTid == t) mState[t] = 1;
        else if (acc && rt == t) mState[t] = stall[t] ? 4 : 3;
        else if (mState[t] == 0 && stall[t]) mState[t] = 4;
        else if (mState[t] == 3) mState[t] = stall[t] ? 4 : 0;
        else if (mState[t] == 4 && !stall[t]) mState[t] = 0;
      end
      if (issue) begin
        mSeq[ft] = (mSeq[ft] + 1) % (1 << SW); mValid[ft] = 0; mTag[ft] = al;
      end
      if (acc) begin mValid[rt] = 1; mData[rt] = rspData; end
      else if (rspValid) mDrop++;
      if (issue && !reqReady) mBlocked = 1;
      else if (retryPulse) mBlocked = resend && !reqReady;
      if (issue && !reqReady) begin mSlotV = 1; mSlotTid = ft; mSlotAddr = al; end
      else if (resend && reqReady) mSlotV = 0;
      else if (mSlotV && squash[mSlotTid]) mSlotV = 0;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    fetchValid = 0; rspValid = 0; retryPulse = 0; squash = 0;
  endtask

  function automatic logic [DW-1:0] rnd_line();
    logic [DW-1:0] d;
    for (int i = 0; i < DW / 32; i++) d[32*i +: 32] = $urandom;
    return d;
  endfunction

  logic [DW-1:0] lineA;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R10: reset state
    chk(threadState == 0 && lineValid == 0, "R10", "reset state", threadState, 0);
    chk(!fetchBlocked && dropCount == 0, "R10", "reset flags", dropCount, 0);
    tick();
    // R1/R8: miss on thread 0
    fetchValid = 1; fetchTid = 0; fetchPc = 32'h1234;
    @(negedge clk);
    chk(reqValid && reqAddr == 32'h1220, "R1", "aligned request", reqAddr, 32'h1220);
    chk(reqSeq == 1, "R8", "first seq", reqSeq, 1);
    tick();
    lineA = rnd_line();
    rspValid = 1; rspTid = 0; rspSeq = 1; rspData = lineA;
    tick();
    @(negedge clk);
    chk(threadState[2:0] == 3 && lineValid[0], "R6", "fill complete", threadState[2:0], 3);
    tick();
    // R2: hit in same line
    fetchValid = 1; fetchTid = 0; fetchPc = 32'h123C;
    @(negedge clk);
    chk(fetchHit && !reqValid, "R2", "hit no request", reqValid, 0);
    chk(lineData == lineA, "R2", "hit data", lineData[31:0], lineA[31:0]);
    tick();
    // R3: refusal blocks every thread
    reqReady = 0; fetchValid = 1; fetchTid = 1; fetchPc = 32'h4000;
    tick();
    @(negedge clk);
    chk(fetchBlocked && threadState[5:3] == 2, "R3", "refused", threadState[5:3], 2);
    fetchValid = 1; fetchTid = 2; fetchPc = 32'h8000;
    @(negedge clk);
    chk(!reqValid, "R3", "blocked other thread", reqValid, 0);
    tick();
    // R4: retry resend accepted
    reqReady = 1; retryPulse = 1;
    @(negedge clk);
    chk(reqValid && reqAddr == 32'h4000 && reqTid == 1, "R4", "resend", reqAddr, 32'h4000);
    tick();
    @(negedge clk);
    chk(!fetchBlocked && threadState[5:3] == 1, "R4", "after resend", threadState[5:3], 1);
    // R7: squash owner of the slot
    reqReady = 0; fetchValid = 1; fetchTid = 2; fetchPc = 32'h8000;
    tick();
    reqReady = 1; squash = 4'b0100;
    tick();
    @(negedge clk);
    chk(threadState[8:6] == 0 && fetchBlocked, "R7", "squash slot owner", threadState[8:6], 0);
    retryPulse = 1;
    @(negedge clk);
    chk(!reqValid, "R4", "retry with empty slot", reqValid, 0);
    tick();
    @(negedge clk);
    chk(!fetchBlocked, "R4", "empty retry unblocks", fetchBlocked, 0);
    // R5: stale response after squash and reissue
    squash = 4'b0010;
    tick();
    fetchValid = 1; fetchTid = 1; fetchPc = 32'h4008;
    tick();
    rspValid = 1; rspTid = 1; rspSeq = 1; rspData = rnd_line();
    tick();
    @(negedge clk);
    chk(dropCount == 1 && threadState[5:3] == 1, "R5", "stale dropped", dropCount, 1);
    rspValid = 1; rspTid = 1; rspSeq = 2; stall = 4'b0010;
    tick();
    @(negedge clk);
    chk(threadState[5:3] == 4 && lineValid[1], "R9", "fill while stalled", threadState[5:3], 4);
    stall = 0;
    tick();
    @(negedge clk);
    chk(threadState[5:3] == 0, "R9", "unstall", threadState[5:3], 0);
    // random phase, compared every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      automatic int tt = $urandom_range(0, 3);
      fetchValid = ($urandom_range(0, 9) < 6);
      fetchTid = 2'($urandom_range(0, 3));
      fetchPc = 32'(($urandom_range(0, 5) << 5) | $urandom_range(0, 31));
      reqReady = ($urandom_range(0, 9) < 7);
      retryPulse = ($urandom_range(0, 9) == 0);
      rspValid = ($urandom_range(0, 9) < 3);
      rspTid = 2'(tt);
      rspSeq = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'(mSeq[tt]);
      rspData = rnd_line();
      squash = ($urandom_range(0, 29) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'b0;
      stall = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
      @(posedge clk); #1;
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule